// File: doc/BRIEF.md
# Memory barrier and low-power entry controller

This block carries out a barrier instruction on behalf of a simple in-order pipeline. When the decode stage issues the barrier, the block takes a 5-bit immediate and the current user-mode flag. It then holds the pipeline stalled until the chosen memory sides have no accesses left in flight. Each side reports its in-flight accesses as a plain counter, and a side counts as drained when its counter reads zero.

The two low immediate bits choose which sides to wait on. The pattern that waits on the fetch side only also clears the branch target cache and the prefetch buffer when the barrier completes. The two high immediate bits request one of three low-power states. The block enters that state only once both sides are fully drained. It keeps the pipeline halted until any wakeup line goes high.

When memory management is enabled, the top immediate bit makes the barrier privileged. Issuing it in user mode then raises an exception instead of running the barrier. The fixed part of the latency depends on the interconnect flavour, which is set by a parameter.

Top module: `mem_barrier_ctrl`

## Requirements
- R1: After reset, stall_o, pc_inc_o, fetch_flush_o, exc_o, sleep_o, hibernate_o and suspend_o are all low, and exc_cause_o is zero.
- R2: When imm_i bit 0 is 0, the barrier does not complete until iside_cnt_i reads zero. When imm_i bit 0 is 1 and no low-power state is requested, iside_cnt_i is ignored.
- R3: When imm_i bit 1 is 0, the barrier does not complete until dside_cnt_i reads zero. When imm_i bit 1 is 1 and no low-power state is requested, dside_cnt_i is ignored.
- R4: stall_o stays high for BASE cycles plus one cycle for each drain check that finds a waited-on counter non-zero. Drain checks happen once per cycle, starting with the first cycle after issue. BASE is 2 when COHERENT=0 and 8 when COHERENT=1.
- R5: A barrier that completes normally pulses pc_inc_o for exactly one cycle, in the last stalled cycle before completion.
- R6: When imm_i[1:0] is 2'b10, fetch_flush_o pulses together with pc_inc_o. For any other value of imm_i[1:0] it stays low.
- R7: imm_i[4:3] selects the low-power state: 2'b10 is sleep, 2'b01 is hibernate, 2'b11 is suspend, and 2'b00 is none. At most one of sleep_o, hibernate_o and suspend_o is high at any time.
- R8: A low-power request waits on both counters reaching zero, whatever imm_i[1:0] holds. The state output rises in the cycle after the pc_inc_o pulse, and stall_o stays high while it is set.
- R9: With USE_MMU=1, imm_i[4]=1 and user_mode_i=1, the block does the following: exc_o is high for one stalled cycle with exc_cause_o=5'd7, pc_inc_o stays low, and no low-power state is entered. The next cycle is idle.
- R10: While a low-power state is held, wakeup_i at zero keeps it held. Any non-zero wakeup_i drops the state output and stall_o at the same clock edge.
- R11: start_i is ignored while stall_o is high. The command already running keeps its latency and outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Barrier issued this cycle |
| imm_i | input | 5 | Barrier immediate |
| user_mode_i | input | 1 | Processor in user mode |
| iside_cnt_i | input | CNT_W | Fetch-side accesses in flight |
| dside_cnt_i | input | CNT_W | Data-side accesses in flight |
| wakeup_i | input | WAKE_W | Wakeup request lines |
| stall_o | output | 1 | Pipeline hold |
| pc_inc_o | output | 1 | Advance PC by 4 |
| fetch_flush_o | output | 1 | Clear branch target cache and prefetch buffer |
| sleep_o | output | 1 | Sleep state held |
| hibernate_o | output | 1 | Hibernate state held |
| suspend_o | output | 1 | Suspend state held |
| exc_o | output | 1 | Privileged-instruction exception |
| exc_cause_o | output | 5 | Exception cause code |

## Verification
Random immediates in the non-sleep range, with random counter pairs that drain one per cycle, separate the four drain masks. A wrong mask shows up as a stall length that differs from the larger of the waited-on counters. Each barrier runs on a basic-latency instance and a coherent-latency instance side by side, so the fixed latency term is checked on its own. Directed cases do the following:
- drive all three low-power codes with one counter deliberately left unwaited, which tells mode decoding apart from the forced full drain;
- issue privileged codes in user mode and in kernel mode;
- pulse wakeup on each line;
- re-issue start during a drain and during a held state, which shows that it is ignored.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_TAIL, ST_EXC, ST_LP
  } mbc_state_e;

  typedef enum logic [1:0] {
    LP_NONE  = 2'b00,
    LP_HIB   = 2'b01,
    LP_SLEEP = 2'b10,
    LP_SUSP  = 2'b11
  } lp_mode_e;

  typedef struct packed {
    logic     wait_i;
    logic     wait_d;
    logic     flush;
    lp_mode_e lp;
  } bar_cmd_t;

  localparam int IMM_W = 5;
  localparam logic [4:0] PRIV_CAUSE = 5'd7;
endpackage

// File: rtl/mbc_decode.sv
module mbc_decode
  import mbc_pkg::*;
#(
  parameter bit USE_MMU = 1'b1
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             user_mode_i,
  output bar_cmd_t         cmd_o,
  output logic             priv_viol_o
);
  lp_mode_e lp;

  always_comb begin
    lp           = lp_mode_e'(imm_i[4:3]);
    cmd_o.lp     = lp;
    // low-power entry drains both sides regardless of the mask
    cmd_o.wait_i = ~imm_i[0] | (lp != LP_NONE);
    cmd_o.wait_d = ~imm_i[1] | (lp != LP_NONE);
    cmd_o.flush  = imm_i[1] & ~imm_i[0];
    priv_viol_o  = USE_MMU & imm_i[4] & user_mode_i;
  end
endmodule

// File: rtl/mbc_drain.sv
module mbc_drain #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] iside_cnt_i,
  input  logic [CNT_W-1:0] dside_cnt_i,
  input  logic             wait_i_i,
  input  logic             wait_d_i,
  output logic             drained_o
);
  logic i_ok, d_ok;

  always_comb begin
    i_ok      = ~wait_i_i | (iside_cnt_i == '0);
    d_ok      = ~wait_d_i | (dside_cnt_i == '0);
    drained_o = i_ok & d_ok;
  end
endmodule

// File: rtl/mbc_tail_cnt.sv
module mbc_tail_cnt #(
  parameter int BASE_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (BASE_LAT > 2) ? $clog2(BASE_LAT - 1) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(BASE_LAT - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_V;
    else if (en_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  p_tail_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LOAD_V));
endmodule

// File: rtl/mem_barrier_ctrl.sv
module mem_barrier_ctrl
  import mbc_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int WAKE_W   = 2,
  parameter bit USE_MMU  = 1'b1,
  parameter bit COHERENT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              user_mode_i,
  input  logic [CNT_W-1:0]  iside_cnt_i,
  input  logic [CNT_W-1:0]  dside_cnt_i,
  input  logic [WAKE_W-1:0] wakeup_i,
  output logic              stall_o,
  output logic              pc_inc_o,
  output logic              fetch_flush_o,
  output logic              sleep_o,
  output logic              hibernate_o,
  output logic              suspend_o,
  output logic              exc_o,
  output logic [4:0]        exc_cause_o
);
  localparam int BASE_LAT = COHERENT ? 8 : 2;

  mbc_state_e state_q, state_d;
  bar_cmd_t   cmd_q, cmd_dec;
  logic       priv_viol, drained, tail_last, tail_load, done, lp_any;

  mbc_decode #(.USE_MMU(USE_MMU)) u_decode (
    .imm_i       (imm_i),
    .user_mode_i (user_mode_i),
    .cmd_o       (cmd_dec),
    .priv_viol_o (priv_viol)
  );

  mbc_drain #(.CNT_W(CNT_W)) u_drain (
    .iside_cnt_i (iside_cnt_i),
    .dside_cnt_i (dside_cnt_i),
    .wait_i_i    (cmd_q.wait_i),
    .wait_d_i    (cmd_q.wait_d),
    .drained_o   (drained)
  );

  assign tail_load = (state_q == ST_DRAIN) && drained;

  mbc_tail_cnt #(.BASE_LAT(BASE_LAT)) u_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tail_load),
    .en_i   (state_q == ST_TAIL),
    .last_o (tail_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = priv_viol ? ST_EXC : ST_DRAIN;
      ST_DRAIN: if (drained) state_d = ST_TAIL;
      ST_TAIL:  if (tail_last) state_d = (cmd_q.lp != LP_NONE) ? ST_LP : ST_IDLE;
      ST_EXC:   state_d = ST_IDLE;
      ST_LP:    if (|wakeup_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) cmd_q <= cmd_dec;
    end
  end

  always_comb begin
    done          = (state_q == ST_TAIL) && tail_last;
    stall_o       = (state_q != ST_IDLE);
    pc_inc_o      = done;
    fetch_flush_o = done && cmd_q.flush;
    sleep_o       = (state_q == ST_LP) && (cmd_q.lp == LP_SLEEP);
    hibernate_o   = (state_q == ST_LP) && (cmd_q.lp == LP_HIB);
    suspend_o     = (state_q == ST_LP) && (cmd_q.lp == LP_SUSP);
    exc_o         = (state_q == ST_EXC);
    exc_cause_o   = exc_o ? PRIV_CAUSE : 5'd0;
    lp_any        = sleep_o | hibernate_o | suspend_o;
  end

  p_lp_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sleep_o, hibernate_o, suspend_o}));

  p_lp_full_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_load && cmd_q.lp != LP_NONE) |-> (iside_cnt_i == '0 && dside_cnt_i == '0));

  p_lp_after_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_any) |-> $past(pc_inc_o));

  p_exc_no_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !pc_inc_o);

  p_exc_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> (!stall_o && !lp_any));

  p_wake_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_any && |wakeup_i) |=> (!stall_o && !lp_any));

  p_pc_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> !pc_inc_o);

  p_flush_with_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_flush_o |-> pc_inc_o);
endmodule

// File: tb/mem_barrier_ctrl_bench.sv
module mem_barrier_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 4;
  localparam int WAKE_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, user = 1'b0;
  logic [4:0] imm = '0;
  logic [CNT_W-1:0] icnt = '0, dcnt = '0;
  logic [WAKE_W-1:0] wake = '0;

  logic a_stall, a_pc, a_fl, a_sl, a_hb, a_su, a_ex;
  logic b_stall, b_pc, b_fl, b_sl, b_hb, b_su, b_ex;
  logic [4:0] a_cause, b_cause;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_barrier_ctrl #(.CNT_W(CNT_W), .WAKE_W(WAKE_W), .USE_MMU(1'b1), .COHERENT(1'b0)) u_mem_barrier_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_i(imm), .user_mode_i(user),
    .iside_cnt_i(icnt), .dside_cnt_i(dcnt), .wakeup_i(wake),
    .stall_o(a_stall), .pc_inc_o(a_pc), .fetch_flush_o(a_fl), .sleep_o(a_sl),
    .hibernate_o(a_hb), .suspend_o(a_su), .exc_o(a_ex), .exc_cause_o(a_cause));

  mem_barrier_ctrl #(.CNT_W(CNT_W), .WAKE_W(WAKE_W), .USE_MMU(1'b1), .COHERENT(1'b1)) u_mem_barrier_ctrl_coh (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_i(imm), .user_mode_i(user),
    .iside_cnt_i(icnt), .dside_cnt_i(dcnt), .wakeup_i(wake),
    .stall_o(b_stall), .pc_inc_o(b_pc), .fetch_flush_o(b_fl), .sleep_o(b_sl),
    .hibernate_o(b_hb), .suspend_o(b_su), .exc_o(b_ex), .exc_cause_o(b_cause));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int base, input logic [4:0] im, input int ic, input int dc);
    bit lp = (im[4:3] != 2'b00);
    int m = 0;
    if (!im[0] || lp) m = (ic > m) ? ic : m;
    if (!im[1] || lp) m = (dc > m) ? dc : m;
    return base + ((m > 1) ? m - 1 : 0);
  endfunction

  function automatic bit exp_flush(input logic [4:0] im);
    return im[1:0] == 2'b10;
  endfunction

  // Issue one barrier; counters drain by one per cycle. poke re-issues start mid-drain.
  task automatic run_barrier(input logic [4:0] im, input logic um, input int ic, input int dc,
                             input bit poke);
    int a_cyc = 0, b_cyc = 0, a_pcn = 0, b_pcn = 0, a_fln = 0, b_fln = 0, a_exn = 0, b_exn = 0;
    bit a_done = 0, b_done = 0, exc_exp;
    logic [1:0] md;
    exc_exp = im[4] && um;
    md = im[4:3];
    @(negedge clk);
    imm = im; user = um; icnt = CNT_W'(ic); dcnt = CNT_W'(dc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (!a_done) begin
        if (a_stall && !(a_sl || a_hb || a_su)) begin
          a_cyc++; a_pcn += int'(a_pc); a_fln += int'(a_fl);
          if (a_ex) begin a_exn++; check(a_cause == 5'd7, "R9 cause", a_cause, 7); end
        end else a_done = 1;
      end
      if (!b_done) begin
        if (b_stall && !(b_sl || b_hb || b_su)) begin
          b_cyc++; b_pcn += int'(b_pc); b_fln += int'(b_fl);
          if (b_ex) b_exn++;
        end else b_done = 1;
      end
      if (icnt != 0) icnt = icnt - 1'b1;
      if (dcnt != 0) dcnt = dcnt - 1'b1;
      if (a_done && b_done) break;
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 0) begin
        imm = 5'b10000; user = 1'b1; start = 1'b1;   // R11: would trap if accepted
      end
    end
    start = 1'b0;
    if (exc_exp) begin
      check(a_cyc == 1 && b_cyc == 1, "R9 stall length", a_cyc, 1);
      check(a_exn == 1 && b_exn == 1, "R9 exc pulse", a_exn, 1);
      check(a_pcn == 0 && b_pcn == 0, "R9 no pc advance", a_pcn, 0);
      check(!(a_sl || a_hb || a_su || a_stall), "R9 no low-power", a_stall, 0);
    end else begin
      check(a_cyc == exp_lat(2, im, ic, dc), "R4/R2/R3 latency basic", a_cyc, exp_lat(2, im, ic, dc));
      check(b_cyc == exp_lat(8, im, ic, dc), "R4 latency coherent", b_cyc, exp_lat(8, im, ic, dc));
      check(a_pcn == 1 && b_pcn == 1, "R5 pc pulse", a_pcn, 1);
      check(a_fln == int'(exp_flush(im)) && b_fln == int'(exp_flush(im)), "R6 flush", a_fln, int'(exp_flush(im)));
      check(a_exn == 0 && b_exn == 0, "R9 no exc", a_exn, 0);
      check(a_sl == (md == 2'b10) && a_hb == (md == 2'b01) && a_su == (md == 2'b11),
            "R7 mode basic", {a_sl, a_hb, a_su}, md);
      check(b_sl == (md == 2'b10) && b_hb == (md == 2'b01) && b_su == (md == 2'b11),
            "R7 mode coherent", {b_sl, b_hb, b_su}, md);
      if (md != 2'b00) check(a_stall && b_stall, "R8 stall held", a_stall, 1);
    end
  endtask

  task automatic wake_up(input int line);
    repeat (3) @(negedge clk);
    check(a_stall && b_stall && (a_sl || a_hb || a_su), "R10 held without wakeup", a_stall, 1);
    imm = 5'b00000; user = 1'b0; start = 1'b1;   // R11 start while held
    @(negedge clk);
    start = 1'b0;
    check(a_stall && (a_sl || a_hb || a_su), "R11 start ignored in low-power", a_stall, 1);
    wake = WAKE_W'(1 << line);
    @(negedge clk);
    wake = '0;
    check(!a_stall && !b_stall, "R10 stall released", a_stall, 0);
    check(!(a_sl || a_hb || a_su || b_sl || b_hb || b_su), "R10 state dropped", a_sl, 0);
    @(negedge clk);
    check(!a_stall && !b_stall && !a_pc, "R11 no phantom barrier", a_stall, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!a_stall && !a_pc && !a_fl && !a_ex && !a_sl && !a_hb && !a_su && a_cause == 0,
          "R1 reset basic", a_stall, 0);
    check(!b_stall && !b_pc && !b_fl && !b_ex && !b_sl && !b_hb && !b_su && b_cause == 0,
          "R1 reset coherent", b_stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!a_stall && !b_stall, "R1 idle after reset", a_stall, 0);

    // directed drain masks
    run_barrier(5'b00000, 0, 6, 3, 0);   // R2 R3 both waited
    run_barrier(5'b00001, 0, 9, 2, 0);   // R3 only data, i ignored
    run_barrier(5'b00010, 0, 1, 9, 0);   // R2 only fetch, d ignored, R6 flush
    run_barrier(5'b00011, 0, 9, 9, 0);   // neither
    run_barrier(5'b00000, 0, 5, 0, 1);   // R11 start during drain

    // low-power: unwaited counter must still drain (R8)
    run_barrier(5'b10011, 0, 4, 7, 0); wake_up(0);   // sleep
    run_barrier(5'b01001, 1, 2, 6, 0); wake_up(1);   // hibernate, user mode not privileged
    run_barrier(5'b11010, 0, 8, 1, 0); wake_up(1);   // suspend

    // privilege R9
    run_barrier(5'b10000, 1, 3, 3, 0);
    run_barrier(5'b11000, 1, 0, 0, 0);
    run_barrier(5'b10010, 1, 5, 0, 0);

    // random non-sleep mix
    for (int i = 0; i < 40; i++) begin
      logic [4:0] r;
      r = {2'b00, 3'($urandom)};
      run_barrier(r, 1'($urandom), int'($urandom % 11), int'($urandom % 11), 0);
    end

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule